// File: doc/BRIEF.md
# Two-Level Local Pattern Branch Predictor

This block predicts the direction of a conditional branch from that branch's own recent outcomes. A first table, selected by a few low bits of the branch address, keeps a short shift register of past outcomes for each slot. The value in that shift register then selects one 2-bit saturating counter in a second table, and the counter's upper bit is the prediction. Repeating patterns, such as a loop that is taken three times and then falls through, are learned exactly, because each position in the pattern reaches the second table with a different history value.

The lookup port is purely combinational. A fetch address goes in, and a taken or not-taken answer comes out in the same cycle, after two dependent table reads. The update port is used when a branch resolves. It takes the branch address and the real outcome. On the next clock edge it nudges the counter that the old history pointed at, and it shifts the outcome into that slot's history. Slots carry no tag, so branches that share index bits share one history.

Top module: `local_pattern_predictor`

## Requirements
- R1: After synchronous active-low reset, every history slot holds zero and every counter holds 2'b01 (weakly not taken), so every lookup predicts not taken.
- R2: A lookup uses address bits [IDX_LSB +: IDX_W] (bits 5:2 by default) to select a history slot. That history value selects a counter, and the prediction is the counter's bit 1. The answer is valid in the same cycle as the address.
- R3: On an update, the counter selected by the slot's history before the update is incremented for taken and decremented for not taken. It saturates at 0 and 3.
- R4: On an update, the slot's history becomes {old[HIST_W-2:0], outcome}. A taken outcome shifts in a 1 at bit 0.
- R5: Addresses that differ only outside the index bits (upper bits, or the two lowest bits) share one history slot. No tag check is made.
- R6: When a lookup and an update fall in the same cycle, the lookup returns the prediction from the state before the update. The update is visible from the next cycle.
- R7: While the update valid input is low, no history slot or counter changes, whatever the other update inputs carry.
- R8: With a 3-bit history, a branch that repeats the outcome pattern taken, taken, taken, not taken is predicted correctly on every execution once it has warmed up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_pred | output | 1 | Prediction, 1 = taken |
| up_valid | input | 1 | Apply an update this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A lookup and an update can arrive in the same cycle for the same branch, because a resolving branch and a new fetch of it may overlap. The bench sets up a slot whose counter will change its upper bit. It then drives the lookup and the update for that slot together, and samples the prediction before the clock edge and again after it. The value before the edge must match the pre-update state and the value after it must match the post-update state, both taken from a reference model of the requirements kept inside the bench.

// File: rtl/lhp_pkg.sv
// Package: shared types and the counter step rule for the local predictor.
// Assumes 2-bit counters; bit 1 is the predicted direction.
package lhp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'b01;
    localparam ctr_t CTR_MAX   = 2'b11;
    localparam ctr_t CTR_MIN   = 2'b00;

    // Next counter value after one outcome, saturating at both ends.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken)
            nxt = (cur == CTR_MAX) ? cur : cur + 2'd1;
        else
            nxt = (cur == CTR_MIN) ? cur : cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/lhp_history_table.sv
// First-level table: one outcome shift register per slot, indexed by
// address bits. Two combinational read ports (lookup and update) and one
// write port. Assumes HIST_W >= 1. Newest outcome enters at bit 0.
module lhp_history_table #(
    parameter int IDX_W  = 4,
    parameter int HIST_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_taken,
    output logic [HIST_W-1:0] wr_old_hist
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0][HIST_W-1:0] hist_q;
    logic [HIST_W-1:0]            hist_next;

    // Read both ports from the registered state.
    assign rd_hist     = hist_q[rd_idx];
    assign wr_old_hist = hist_q[wr_idx];

    // Form the shifted history; width 1 needs no shift.
    generate
        if (HIST_W == 1) begin : g_hist_one
            assign hist_next = wr_taken;
        end else begin : g_hist_shift
            assign hist_next = {wr_old_hist[HIST_W-2:0], wr_taken};
        end
    endgenerate

    // Clear on reset, otherwise write the shifted history of the updated slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (wr_en)
            hist_q[wr_idx] <= hist_next;
    end

    // R4
    hist_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hist_q[$past(wr_idx)][0] == $past(wr_taken));

    // R7
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(hist_q));

endmodule

// File: rtl/lhp_counter_table.sv
// Second-level table: 2^HIST_W saturating 2-bit counters indexed by a
// history value. One combinational read port, one read-modify-write port.
module lhp_counter_table
    import lhp_pkg::*;
#(
    parameter int HIST_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] rd_hist,
    output ctr_t              rd_ctr,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_hist,
    input  logic              wr_taken
);
    localparam int DEPTH = 1 << HIST_W;

    logic [DEPTH-1:0][1:0] ctr_q;

    // Lookup read from the registered counters.
    assign rd_ctr = ctr_q[rd_hist];

    // Reset to weakly not taken, otherwise step the selected counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctr_q <= {DEPTH{CTR_RESET}};
        else if (wr_en)
            ctr_q[wr_hist] <= ctr_step(ctr_q[wr_hist], wr_taken);
    end

    // R3
    ctr_top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && ctr_q[wr_hist] == CTR_MAX)
        |=> ctr_q[$past(wr_hist)] == CTR_MAX);

    // R3
    ctr_bottom_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && ctr_q[wr_hist] == CTR_MIN)
        |=> ctr_q[$past(wr_hist)] == CTR_MIN);

    // R7
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctr_q));

endmodule

// File: rtl/local_pattern_predictor.sv
// Top: two-level local-history direction predictor. The lookup is
// combinational through both tables; the update takes effect at the next
// clock edge. Index bits are lk_pc/up_pc[IDX_LSB +: IDX_W]; no tags.
module local_pattern_predictor
    import lhp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 4,
    parameter int HIST_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_pred,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  up_idx;
    logic [HIST_W-1:0] lk_hist;
    logic [HIST_W-1:0] up_old_hist;
    ctr_t              lk_ctr;

    // Slice the slot index out of both addresses.
    assign lk_idx = lk_pc[IDX_LSB +: IDX_W];
    assign up_idx = up_pc[IDX_LSB +: IDX_W];

    lhp_history_table #(
        .IDX_W  (IDX_W),
        .HIST_W (HIST_W)
    ) u_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx      (lk_idx),
        .rd_hist     (lk_hist),
        .wr_en       (up_valid),
        .wr_idx      (up_idx),
        .wr_taken    (up_taken),
        .wr_old_hist (up_old_hist)
    );

    lhp_counter_table #(
        .HIST_W (HIST_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hist  (lk_hist),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_hist  (up_old_hist),
        .wr_taken (up_taken)
    );

    // Direction is the counter's upper bit.
    assign lk_pred = lk_ctr[1];

endmodule

// File: tb/local_pattern_predictor_bench.sv
// Directed bench with a reference model built from the requirements.
module local_pattern_predictor_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_pred;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;

    int checks = 0;
    int errors = 0;

    // Reference state: 16 slots of 3-bit history, 8 counters.
    logic [2:0] mh [16];
    logic [1:0] mc [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    local_pattern_predictor #(
        .PC_W(32), .IDX_LSB(2), .IDX_W(4), .HIST_W(3)
    ) u_local_pattern_predictor (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_pred(lk_pred),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    function automatic logic model_pred(input logic [31:0] pc);
        return mc[mh[pc[5:2]]][1];
    endfunction

    task automatic model_update(input logic [31:0] pc, input logic t);
        logic [2:0] h;
        h = mh[pc[5:2]];
        if (t && mc[h] != 2'd3) mc[h] = mc[h] + 2'd1;
        else if (!t && mc[h] != 2'd0) mc[h] = mc[h] - 2'd1;
        mh[pc[5:2]] = {h[1:0], t};
    endtask

    task automatic check(input logic got, input logic exp, input string req,
                         input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        up_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mh[i] = 3'b000;
        for (int i = 0; i < 8; i++) mc[i] = 2'b01;
    endtask

    task automatic look(input logic [31:0] pc, output logic p);
        @(negedge clk);
        lk_pc = pc;
        #1 p = lk_pred;
    endtask

    task automatic upd(input logic [31:0] pc, input logic t);
        @(negedge clk);
        up_valid = 1'b1;
        up_pc = pc;
        up_taken = t;
        @(posedge clk);
        #1 up_valid = 1'b0;
        model_update(pc, t);
    endtask

    // R1: reset state predicts not taken everywhere.
    task automatic test_reset();
        logic p;
        apply_reset();
        for (int i = 0; i < 4; i++) begin
            look(32'h100 + 32'(i * 20), p);
            check(p, 1'b0, "R1", "reset lookup");
        end
    endtask

    // R2/R3/R4: mixed outcomes on two branches, compared with the model.
    task automatic test_mixed();
        logic p;
        logic [7:0] pat = 8'b1011_0110;
        apply_reset();
        for (int i = 0; i < 8; i++) begin
            upd(32'h20, pat[i]);
            upd(32'h34, ~pat[i]);
            look(32'h20, p);
            check(p, model_pred(32'h20), "R2", "mixed lookup A");
            look(32'h34, p);
            check(p, model_pred(32'h34), "R4", "mixed lookup B");
        end
    endtask

    // R3: counter saturation at both ends.
    task automatic test_saturation();
        logic p;
        apply_reset();
        for (int i = 0; i < 10; i++) upd(32'h8, 1'b1);
        upd(32'h8, 1'b0);
        for (int i = 0; i < 3; i++) upd(32'h8, 1'b1);
        look(32'h8, p);
        check(p, 1'b1, "R3", "upper saturation");
        apply_reset();
        for (int i = 0; i < 10; i++) upd(32'h8, 1'b0);
        upd(32'h8, 1'b1);
        for (int i = 0; i < 3; i++) upd(32'h8, 1'b0);
        look(32'h8, p);
        check(p, 1'b0, "R3", "lower saturation");
        check(p, model_pred(32'h8), "R3", "lower saturation model");
    endtask

    // R5: aliasing of upper and lowest address bits.
    task automatic test_alias();
        logic p;
        apply_reset();
        for (int i = 0; i < 3; i++) upd(32'h10, 1'b1);
        look(32'h50, p);
        check(p, 1'b0, "R5", "alias sees shared history 111");
        look(32'h14, p);
        check(p, 1'b1, "R5", "other slot history 000");
        upd(32'h50, 1'b1);
        look(32'h10, p);
        check(p, 1'b1, "R5", "alias update moves shared slot");
        look(32'h13, p);
        check(p, 1'b1, "R5", "low bits ignored");
    endtask

    // R6: lookup and update of the same slot in one cycle.
    task automatic test_same_cycle();
        logic p;
        apply_reset();
        upd(32'h4, 1'b1);
        @(negedge clk);
        lk_pc = 32'h8;
        up_valid = 1'b1;
        up_pc = 32'h8;
        up_taken = 1'b0;
        #1 p = lk_pred;
        check(p, 1'b1, "R6", "same cycle returns old state");
        @(posedge clk);
        #1 up_valid = 1'b0;
        model_update(32'h8, 1'b0);
        p = lk_pred;
        check(p, 1'b0, "R6", "update visible next cycle");
        check(p, model_pred(32'h8), "R6", "post update model");
    endtask

    // R7: update inputs with valid low change nothing.
    task automatic test_idle();
        logic p;
        apply_reset();
        upd(32'h4, 1'b1);
        @(negedge clk);
        up_valid = 1'b0;
        up_pc = 32'h8;
        up_taken = 1'b0;
        repeat (4) @(negedge clk);
        up_taken = 1'b1;
        up_pc = 32'h4;
        repeat (4) @(negedge clk);
        look(32'h8, p);
        check(p, 1'b1, "R7", "idle slot unchanged");
        look(32'h4, p);
        check(p, 1'b0, "R7", "idle trained slot unchanged");
    endtask

    // R8: loop pattern 1110 predicted perfectly after warm-up.
    task automatic test_loop();
        logic p;
        logic o;
        apply_reset();
        for (int it = 0; it < 12; it++) begin
            for (int k = 0; k < 4; k++) begin
                o = (k != 3);
                look(32'h40, p);
                if (it == 0 && k == 0) check(p, 1'b0, "R1", "cold loop lookup");
                if (it >= 4) check(p, o, "R8", "warm loop lookup");
                upd(32'h40, o);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_mixed();
        test_saturation();
        test_alias();
        test_same_cycle();
        test_idle();
        test_loop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule